// File: doc/BRIEF.md
# Bang-Bang Clock-and-Data-Recovery Phase Loop

This block is the digital core of a clock-and-data-recovery loop. An external sampler takes two samples for each received symbol: one at the centre of the symbol and one on the edge clock, which sits half a symbol period away, between the previous centre sample and the current one. The sampler presents both bits with a valid strobe. The block compares the current centre sample with the previous one and with the edge sample. It concludes that the sampling clock is early or late only when the data has toggled. When the data has not toggled, it makes no decision.

The early/late pulses feed a signed integrating counter. The counter moves the phase-select code by one position each time its count reaches a programmable threshold, and then clears. The phase code drives an external delay line or phase interpolator, which is not part of this block. The code wraps around its range, so a constant frequency offset against the separate frequency reference can be followed indefinitely. The recovered data bit is produced alongside each decision.

Top module: `bbcdr_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `pd_up`, `pd_dn`, `rec_data` and `phase_code` to 0. It also empties the integrator and forgets the previous data sample.
- R2: The first valid strobe after reset produces neither `pd_up` nor `pd_dn`.
- R3: A valid strobe whose data bit differs from the previous valid data bit, and whose edge bit equals the current data bit, raises `pd_up` in the cycle after that clock edge. `pd_dn` stays low in that cycle, and the two pulses are never high together.
- R4: A valid strobe whose data bit differs from the previous valid data bit, and whose edge bit differs from the current data bit, raises `pd_dn` in the cycle after that clock edge. `pd_up` stays low in that cycle.
- R5: A valid strobe whose data bit equals the previous valid data bit raises neither pulse and leaves `phase_code` unchanged.
- R6: A cycle with `smp_vld` low raises no pulse, leaves `rec_data` unchanged and does not replace the stored previous data bit.
- R7: In the cycle after a valid strobe's clock edge, `rec_data` equals that strobe's data bit. This is the same cycle in which that strobe's decision appears.
- R8: Each `pd_up` pulse adds 1 to the integrator. When the count reaches the threshold T, `phase_code` rises by one and the integrator returns to zero. T is `thresh`, or 1 when `thresh` is 0. The new code is visible two clock edges after the strobe edge that caused the final pulse.
- R9: Each `pd_dn` pulse subtracts 1 from the integrator. When the count reaches -T, `phase_code` falls by one with the same latency as in R8, and the integrator returns to zero.
- R10: `phase_code` wraps modulo 2^PHASE_W. A step up from the maximum code gives 0, and a step down from 0 gives the maximum code.
- R11: In a closed loop whose sampler places the edge sample on the new data bit when the code is below a target offset, and on the old data bit otherwise, `phase_code` reaches the target. It then stays within one step of the target, in {target-1, target}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Strobe: a new centre/edge sample pair is present |
| smp_data | input | 1 | Centre (data) sample of the current symbol |
| smp_edge | input | 1 | Edge sample between the previous and current symbol |
| thresh | input | ACC_W-1 | Integrator threshold T (0 treated as 1) |
| pd_up | output | 1 | Registered early decision pulse |
| pd_dn | output | 1 | Registered late decision pulse |
| rec_data | output | 1 | Recovered data bit, aligned with its decision |
| phase_code | output | PHASE_W | Phase-select code for the external delay element |

## Verification
The bench uses the default build: a 6-bit phase code and an 8-bit integrator. With these values, all 64 codes and both wrap points are within a short run. Thresholds from 1 to 127 are available through the `thresh` port. The bench uses 1, 3 and 4 to test step counting, and a large value to hold the code still while the detector truth table is checked. The closed-loop test targets two offsets, and reaching the second one requires the code to cross the mid-range of its values.

// File: rtl/bbcdr_pkg.sv
package bbcdr_pkg;

   // Decision produced by the early/late detector for one symbol
   typedef enum logic [1:0] {
      DEC_HOLD = 2'b00,
      DEC_UP   = 2'b01,
      DEC_DN   = 2'b10
   } bbcdr_dec_e;

   // Early/late rule: only a toggle of the data carries timing information.
   function automatic bbcdr_dec_e bbcdr_decide(input logic cur, input logic prev,
                                               input logic edge_bit);
      bbcdr_dec_e d;
      if (cur == prev)           d = DEC_HOLD;
      else if (edge_bit == cur)  d = DEC_UP;
      else                       d = DEC_DN;
      return d;
   endfunction

endpackage

// File: rtl/bbcdr_pd.sv
module bbcdr_pd
   import bbcdr_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic vld,
   input  logic data_bit,
   input  logic edge_bit,
   output logic up,
   output logic dn,
   output logic rec
);

   logic       prev_q;
   logic       have_prev_q;
   bbcdr_dec_e dec;

   always_comb begin
      dec = bbcdr_decide(data_bit, prev_q, edge_bit);
      if (!vld || !have_prev_q) dec = DEC_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q      <= 1'b0;
         have_prev_q <= 1'b0;
         rec         <= 1'b0;
         up          <= 1'b0;
         dn          <= 1'b0;
      end else begin
         up <= (dec == DEC_UP);
         dn <= (dec == DEC_DN);
         if (vld) begin
            prev_q      <= data_bit;
            have_prev_q <= 1'b1;
            rec         <= data_bit;
         end
      end
   end

endmodule

// File: rtl/bbcdr_integ.sv
module bbcdr_integ #(
   parameter int ACC_W = 8,
   localparam int THR_W = ACC_W - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up,
   input  logic             dn,
   input  logic [THR_W-1:0] thresh,
   output logic             step_up,
   output logic             step_dn
);

   logic signed [ACC_W-1:0] acc_q, acc_d;
   logic signed [ACC_W-1:0] lim_pos, lim_neg;
   logic [THR_W-1:0]        eff_thr;
   logic                    su_d, sd_d;

   always_comb begin
      eff_thr = (thresh == '0) ? THR_W'(1) : thresh;
      lim_pos = $signed({1'b0, eff_thr});
      lim_neg = -lim_pos;
   end

   always_comb begin
      acc_d = acc_q;
      su_d  = 1'b0;
      sd_d  = 1'b0;
      if (up && !dn) begin
         if (acc_q + 1 >= lim_pos) begin
            su_d  = 1'b1;
            acc_d = '0;
         end else begin
            acc_d = acc_q + 1;
         end
      end else if (dn && !up) begin
         if (acc_q - 1 <= lim_neg) begin
            sd_d  = 1'b1;
            acc_d = '0;
         end else begin
            acc_d = acc_q - 1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         step_up <= 1'b0;
         step_dn <= 1'b0;
      end else begin
         acc_q   <= acc_d;
         step_up <= su_d;
         step_dn <= sd_d;
      end
   end

endmodule

// File: rtl/bbcdr_phase.sv
module bbcdr_phase #(
   parameter int PHASE_W = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_up,
   input  logic               step_dn,
   output logic [PHASE_W-1:0] code
);

   // Modulo arithmetic is implicit in the register width.
   always_ff @(posedge clk) begin
      if (rst)                      code <= '0;
      else if (step_up && !step_dn) code <= code + 1'b1;
      else if (step_dn && !step_up) code <= code - 1'b1;
   end

endmodule

// File: rtl/bbcdr_core.sv
module bbcdr_core #(
   parameter int PHASE_W = 6,
   parameter int ACC_W   = 8,
   localparam int THR_W  = ACC_W - 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               smp_vld,
   input  logic               smp_data,
   input  logic               smp_edge,
   input  logic [THR_W-1:0]   thresh,
   output logic               pd_up,
   output logic               pd_dn,
   output logic               rec_data,
   output logic [PHASE_W-1:0] phase_code
);

   if (PHASE_W < 2 || PHASE_W > 16) begin : g_bad_phase_w
      $error("bbcdr_core: PHASE_W must be within 2..16");
   end
   if (ACC_W < 3 || ACC_W > 24) begin : g_bad_acc_w
      $error("bbcdr_core: ACC_W must be within 3..24");
   end

   logic step_up, step_dn;

   bbcdr_pd pd_i (
      .clk      (clk),
      .rst      (rst),
      .vld      (smp_vld),
      .data_bit (smp_data),
      .edge_bit (smp_edge),
      .up       (pd_up),
      .dn       (pd_dn),
      .rec      (rec_data)
   );

   bbcdr_integ #(.ACC_W(ACC_W)) integ_i (
      .clk     (clk),
      .rst     (rst),
      .up      (pd_up),
      .dn      (pd_dn),
      .thresh  (thresh),
      .step_up (step_up),
      .step_dn (step_dn)
   );

   bbcdr_phase #(.PHASE_W(PHASE_W)) phase_i (
      .clk     (clk),
      .rst     (rst),
      .step_up (step_up),
      .step_dn (step_dn),
      .code    (phase_code)
   );

endmodule

// File: rtl/bbcdr_core_chk.sv
module bbcdr_core_chk #(
   parameter int PHASE_W = 6
) (
   input logic               clk,
   input logic               rst,
   input logic               smp_vld,
   input logic               smp_data,
   input logic               smp_edge,
   input logic               pd_up,
   input logic               pd_dn,
   input logic               rec_data,
   input logic               step_up,
   input logic               step_dn,
   input logic [PHASE_W-1:0] phase_code
);

   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   p_excl_r3: assert property (@(posedge clk) disable iff (rst || !armed)
      !(pd_up && pd_dn));

   p_up_src_r3: assert property (@(posedge clk) disable iff (rst || !armed)
      pd_up |-> $past(smp_vld && (smp_data == smp_edge)));

   p_dn_src_r4: assert property (@(posedge clk) disable iff (rst || !armed)
      pd_dn |-> $past(smp_vld && (smp_data != smp_edge)));

   p_idle_r6: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(smp_vld) |-> (!pd_up && !pd_dn && $stable(rec_data)));

   p_rec_r7: assert property (@(posedge clk) disable iff (rst || !armed)
      $past(smp_vld) |-> (rec_data == $past(smp_data)));

   p_step_src_r8: assert property (@(posedge clk) disable iff (rst || !armed)
      step_up |-> $past(pd_up));

   p_step_src_r9: assert property (@(posedge clk) disable iff (rst || !armed)
      step_dn |-> $past(pd_dn));

   p_wrap_up_r10: assert property (@(posedge clk) disable iff (rst || !armed)
      $past(step_up) |-> (phase_code == PHASE_W'($past(phase_code) + 1'b1)));

   p_wrap_dn_r10: assert property (@(posedge clk) disable iff (rst || !armed)
      $past(step_dn) |-> (phase_code == PHASE_W'($past(phase_code) - 1'b1)));

   p_hold_r5: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(step_up || step_dn) |-> $stable(phase_code));

endmodule

bind bbcdr_core bbcdr_core_chk #(.PHASE_W(PHASE_W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .smp_vld    (smp_vld),
   .smp_data   (smp_data),
   .smp_edge   (smp_edge),
   .pd_up      (pd_up),
   .pd_dn      (pd_dn),
   .rec_data   (rec_data),
   .step_up    (step_up),
   .step_dn    (step_dn),
   .phase_code (phase_code)
);

// File: tb/bbcdr_core_tb_top.sv
module bbcdr_core_tb_top;

   localparam int PHASE_W = 6;
   localparam int ACC_W   = 8;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               smp_vld = 1'b0;
   logic               smp_data = 1'b0;
   logic               smp_edge = 1'b0;
   logic [ACC_W-2:0]   thresh = '0;
   logic               pd_up, pd_dn, rec_data;
   logic [PHASE_W-1:0] phase_code;

   int n_chk  = 0;
   int n_fail = 0;
   logic last_bit = 1'b0;

   always #5 clk = ~clk;

   bbcdr_core #(.PHASE_W(PHASE_W), .ACC_W(ACC_W)) dut_i (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
      .smp_edge(smp_edge), .thresh(thresh), .pd_up(pd_up), .pd_dn(pd_dn),
      .rec_data(rec_data), .phase_code(phase_code)
   );

   // {vld, data, edge, exp_up, exp_dn, exp_rec}
   localparam logic [5:0] VEC [12] = '{
      6'b110_001,   // R2 first strobe: no decision
      6'b110_001,   // R5 equal samples
      6'b100_100,   // R3 toggle, edge == data
      6'b110_011,   // R4 toggle, edge != data
      6'b001_001,   // R6 strobe low, ignored
      6'b111_001,   // R6 previous bit kept (1), equal
      6'b101_010,   // R4
      6'b111_101,   // R3
      6'b100_100,   // R3
      6'b011_000,   // R6
      6'b101_000,   // R5 equal to kept 0
      6'b110_011    // R4
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; smp_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      last_bit = 1'b0;
   endtask

   task automatic strobe(input logic d, input logic e);
      smp_vld = 1'b1; smp_data = d; smp_edge = e;
      @(negedge clk);
      smp_vld = 1'b0;
      last_bit = d;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_up();
      strobe(~last_bit, ~last_bit);
   endtask

   task automatic send_dn();
      strobe(~last_bit, last_bit);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 pd_up", int'(pd_up), 0);
      check("R1 pd_dn", int'(pd_dn), 0);
      check("R1 rec_data", int'(rec_data), 0);
      check("R1 phase_code", int'(phase_code), 0);
      rst = 1'b0;
      thresh = 7'd100;

      // Detector truth table walk
      for (int i = 0; i < 12; i++) begin
         smp_vld = VEC[i][5]; smp_data = VEC[i][4]; smp_edge = VEC[i][3];
         @(negedge clk);
         check($sformatf("R3 pd_up vec %0d", i), int'(pd_up), int'(VEC[i][2]));
         check($sformatf("R4 pd_dn vec %0d", i), int'(pd_dn), int'(VEC[i][1]));
         check($sformatf("R7 rec_data vec %0d", i), int'(rec_data), int'(VEC[i][0]));
      end
      smp_vld = 1'b0;
      idle(3);
      check("R5 phase held", int'(phase_code), 0);

      // Threshold stepping with T = 3
      do_reset();
      thresh = 7'd3;
      strobe(1'b0, 1'b0);
      check("R2 no decision after reset", int'(pd_up | pd_dn), 0);
      send_up(); send_up();
      idle(3);
      check("R8 below threshold", int'(phase_code), 0);
      send_up();
      check("R3 pulse", int'(pd_up), 1);
      idle(1);
      check("R8 latency not yet", int'(phase_code), 0);
      idle(1);
      check("R8 step up", int'(phase_code), 1);
      send_dn(); send_dn(); idle(2);
      check("R9 below threshold", int'(phase_code), 1);
      send_dn(); idle(2);
      check("R9 step down", int'(phase_code), 0);
      send_dn(); send_dn(); send_dn(); idle(2);
      check("R10 wrap down", int'(phase_code), 63);
      thresh = 7'd0;   // treated as 1
      send_up(); idle(2);
      check("R10 wrap up (thresh 0 as 1)", int'(phase_code), 0);
      do_reset();
      @(negedge clk);
      check("R1 phase cleared", int'(phase_code), 0);

      // Closed loop tracking
      thresh = 7'd4;
      begin
         logic [15:0] lfsr = 16'hACE1;
         logic [5:0]  target;
         int          bad;
         for (int run = 0; run < 2; run++) begin
            target = (run == 0) ? 6'd20 : 6'd45;
            bad = 0;
            for (int n = 0; n < 640; n++) begin
               logic signed [5:0] diff;
               logic              d;
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               d = lfsr[0];
               diff = $signed(phase_code - target);
               strobe(d, (diff < 0) ? d : last_bit);
               if (n >= 440 && phase_code != target && phase_code != target - 6'd1)
                  bad++;
            end
            check($sformatf("R11 lock window run %0d", run), bad, 0);
         end
      end

      finish_run();
   end

endmodule